// File: doc/BRIEF.md
# Priority-Level Interrupt Controller with Mask

This block collects interrupt requests from a parameterised number of maskable sources and one nonmaskable input. Each maskable source holds a programmable priority level from 1 to 6; a level of 0 turns the source off. The nonmaskable input always carries level 7. A rising edge on any request input sets a sticky pending flag. Among all pending requests, the block forwards only the strongest one, together with that request's fixed vector number. The nonmaskable request has vector 0, and maskable source i has vector i+1.

An acceptance stage compares the forwarded level against a 3-bit mask register. It issues a one-cycle accept strobe when the level is greater than or equal to the mask. The strobe carries the level and vector it accepted. The CPU side then returns an acknowledge with the serviced vector. That acknowledge clears the matching pending flag and allows the next accept.

Two mask operations exist:
- The enable operation loads any value into the mask.
- The disable operation loads 7, so only the nonmaskable request passes.

All pins are plain control and status signals with no back-pressure. The forwarded request is a continuous status view. Only the accept strobe and the acknowledge form a handshake, and exactly one accept is outstanding at a time.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all pending flags are clear, every source level is 0, the mask is 7, and req_valid_o and acc_o are low.
- R2: A maskable source whose level is 0 never appears on the forwarded request and is never accepted.
- R3: The forwarded request carries the highest level among the enabled pending sources. Between sources of equal level, the lower index wins. Maskable source i is reported with vector i+1.
- R4: While the nonmaskable request is pending, the forwarded request is level 7 with vector 0, whatever the maskable sources hold.
- R5: The enable operation (mask_en_i) loads mask_val_i into the mask. A forwarded request is accepted when its level is greater than or equal to the mask, including equality.
- R6: The disable operation (mask_dis_i, which has priority over mask_en_i) loads 7. It blocks every maskable source but still accepts the nonmaskable request.
- R7: A mask write issued at one clock edge is used for the decision in the following cycle. The accept strobe for a request that the new mask admits rises at the next edge after the write.
- R8: A rising edge on irq_i or nmi_i sets a sticky pending flag. An input held high does not set the flag again after that flag has been cleared.
- R9: ack_i with ack_vec_i clears only the pending flag of that vector and releases the acceptance stage. Other pending flags stay set.
- R10: acc_o is high for exactly one cycle per accept. No further accept is issued until ack_i has been seen.
- R11: A level write with lvl_val_i of 7 is stored as 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_SRC | Maskable request inputs, rising-edge sensitive |
| nmi_i | input | 1 | Nonmaskable request, rising-edge sensitive |
| lvl_we_i | input | 1 | Level write strobe |
| lvl_idx_i | input | IDX_W | Source index for a level write |
| lvl_val_i | input | 3 | Level value (0 = off, 7 saturates to 6) |
| mask_en_i | input | 1 | Enable operation: load mask_val_i into the mask |
| mask_val_i | input | 3 | Mask value for the enable operation |
| mask_dis_i | input | 1 | Disable operation: load 7 into the mask |
| ack_i | input | 1 | Acknowledge of the outstanding accept |
| ack_vec_i | input | VEC_W | Vector being acknowledged |
| req_valid_o | output | 1 | A request is being forwarded |
| req_lvl_o | output | 3 | Forwarded priority level |
| req_vec_o | output | VEC_W | Forwarded vector number |
| acc_o | output | 1 | One-cycle accept strobe |
| acc_lvl_o | output | 3 | Level of the accepted request |
| acc_vec_o | output | VEC_W | Vector of the accepted request |

## Verification
Some properties are checked by the assertions on every cycle:
- The accept strobe is one cycle wide.
- No second accept appears while one is outstanding.
- Every accepted level is at least the mask value of the deciding cycle.
- A nonmaskable forward is always level 7, and maskable forwards stay within 1 to 6.

Other behaviour is shown only by the bench scenarios. These cover tie-breaking by index and the exact cycle in which a mask write takes effect. They also cover the sticky flags surviving another source's acknowledge, the held-high input that must not re-trigger, and level saturation.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_OFF = 3'd0;
  localparam lvl_t LVL_TOP = 3'd6;
  localparam lvl_t LVL_NMI = 3'd7;

  function automatic lvl_t sat_level(input lvl_t v);
    return (v > LVL_TOP) ? LVL_TOP : v;
  endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] req_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] req_q;
  logic [WIDTH-1:0] rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_o <= '0;
    end else begin
      req_q  <= req_i;
      pend_o <= (pend_o & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 4
) (
  input  logic [NUM_SRC-1:0]            pend_i,
  input  logic                          nmi_pend_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic                          valid_o,
  output lvl_t                          lvl_o,
  output logic [VEC_W-1:0]              vec_o
);
  lvl_t             best_lvl;
  logic [VEC_W-1:0] best_vec;
  logic             found;

  // Scan from the top index down so that on equal levels the lower index is kept.
  always_comb begin
    best_lvl = LVL_OFF;
    best_vec = '0;
    found    = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && (lvl_i[i] != LVL_OFF) && (lvl_i[i] >= best_lvl)) begin
        best_lvl = lvl_i[i];
        best_vec = VEC_W'(i + 1);
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    if (nmi_pend_i) begin
      valid_o = 1'b1;
      lvl_o   = LVL_NMI;
      vec_o   = '0;
    end else begin
      valid_o = found;
      lvl_o   = best_lvl;
      vec_o   = best_vec;
    end
  end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_pkg::*;
#(
  parameter int VEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_en_i,
  input  lvl_t             mask_val_i,
  input  logic             mask_dis_i,
  input  logic             req_valid_i,
  input  lvl_t             req_lvl_i,
  input  logic [VEC_W-1:0] req_vec_i,
  input  logic             ack_i,
  output logic             acc_o,
  output lvl_t             acc_lvl_o,
  output logic [VEC_W-1:0] acc_vec_o,
  output lvl_t             mask_o
);
  logic busy_q;
  logic fire;

  assign fire = !busy_q && req_valid_i && (req_lvl_i >= mask_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o    <= LVL_NMI;
      busy_q    <= 1'b0;
      acc_o     <= 1'b0;
      acc_lvl_o <= LVL_OFF;
      acc_vec_o <= '0;
    end else begin
      if (mask_dis_i)     mask_o <= LVL_NMI;
      else if (mask_en_i) mask_o <= mask_val_i;

      if (fire)       busy_q <= 1'b1;
      else if (ack_i) busy_q <= 1'b0;

      acc_o <= fire;
      if (fire) begin
        acc_lvl_o <= req_lvl_i;
        acc_vec_o <= req_vec_i;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = $clog2(NUM_SRC),
  parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               nmi_i,
  input  logic               lvl_we_i,
  input  logic [IDX_W-1:0]   lvl_idx_i,
  input  logic [2:0]         lvl_val_i,
  input  logic               mask_en_i,
  input  logic [2:0]         mask_val_i,
  input  logic               mask_dis_i,
  input  logic               ack_i,
  input  logic [VEC_W-1:0]   ack_vec_i,
  output logic               req_valid_o,
  output logic [2:0]         req_lvl_o,
  output logic [VEC_W-1:0]   req_vec_o,
  output logic               acc_o,
  output logic [2:0]         acc_lvl_o,
  output logic [VEC_W-1:0]   acc_vec_o
);
  localparam int NPEND = NUM_SRC + 1;  // bit 0 = nonmaskable, bit i+1 = source i

  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
  logic [NPEND-1:0]              pend;
  logic [NPEND-1:0]              clr;
  lvl_t                          mask_w;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lvl_q[g] <= LVL_OFF;
      else if (lvl_we_i && (lvl_idx_i == IDX_W'(g)))
        lvl_q[g] <= sat_level(lvl_val_i);
    end
  end

  for (genvar g = 0; g < NPEND; g++) begin : g_clr
    assign clr[g] = ack_i && (ack_vec_i == VEC_W'(g));
  end

  irq_pending #(.WIDTH(NPEND)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  ({irq_i, nmi_i}),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
    .pend_i     (pend[NPEND-1:1]),
    .nmi_pend_i (pend[0]),
    .lvl_i      (lvl_q),
    .valid_o    (req_valid_o),
    .lvl_o      (req_lvl_o),
    .vec_o      (req_vec_o)
  );

  irq_accept #(.VEC_W(VEC_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_en_i   (mask_en_i),
    .mask_val_i  (mask_val_i),
    .mask_dis_i  (mask_dis_i),
    .req_valid_i (req_valid_o),
    .req_lvl_i   (req_lvl_o),
    .req_vec_i   (req_vec_o),
    .ack_i       (ack_i),
    .acc_o       (acc_o),
    .acc_lvl_o   (acc_lvl_o),
    .acc_vec_o   (acc_vec_o),
    .mask_o      (mask_w)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_i,
  input logic             acc_o,
  input logic [2:0]       acc_lvl_o,
  input logic             req_valid_o,
  input logic [2:0]       req_lvl_o,
  input logic [VEC_W-1:0] req_vec_o,
  input logic [2:0]       mask_w
);
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     outstanding <= 1'b0;
    else if (ack_i) outstanding <= 1'b0;
    else if (acc_o) outstanding <= 1'b1;
  end

  AST_ACC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |=> !acc_o); // R10
  AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !acc_o); // R10
  AST_ACC_GE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> (acc_lvl_o >= $past(mask_w))); // R5
  AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_vec_o == '0) |-> (req_lvl_o == 3'd7)); // R4
  AST_MASKABLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_vec_o != '0) |-> (req_lvl_o >= 3'd1 && req_lvl_o <= 3'd6)); // R2
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack_i       (ack_i),
  .acc_o       (acc_o),
  .acc_lvl_o   (acc_lvl_o),
  .req_valid_o (req_valid_o),
  .req_lvl_o   (req_lvl_o),
  .req_vec_o   (req_vec_o),
  .mask_w      (mask_w)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC = 8;
  localparam int IDX_W = 3;
  localparam int VEC_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_SRC-1:0] irq_i = '0;
  logic nmi_i = 1'b0;
  logic lvl_we_i = 1'b0;
  logic [IDX_W-1:0] lvl_idx_i = '0;
  logic [2:0] lvl_val_i = '0;
  logic mask_en_i = 1'b0;
  logic [2:0] mask_val_i = '0;
  logic mask_dis_i = 1'b0;
  logic ack_i = 1'b0;
  logic [VEC_W-1:0] ack_vec_i = '0;
  logic req_valid_o;
  logic [2:0] req_lvl_o;
  logic [VEC_W-1:0] req_vec_o;
  logic acc_o;
  logic [2:0] acc_lvl_o;
  logic [VEC_W-1:0] acc_vec_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [6:0] expq[$];  // {level, vector}

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NUM_SRC)) i_prio_irq_ctrl (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every accept strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && acc_o) begin
      if (expq.size() == 0) begin
        check("R10 unexpected accept vec", int'(acc_vec_o), -1);
      end else begin
        logic [6:0] e;
        e = expq.pop_front();
        check("R3/R5 accepted level", int'(acc_lvl_o), int'(e[6:4]));
        check("R3/R5 accepted vector", int'(acc_vec_o), int'(e[3:0]));
      end
    end
  end

  task automatic expect_acc(input int lvl, input int vec);
    expq.push_back({3'(lvl), 4'(vec)});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_lvl(input int idx, input int val);
    @(negedge clk); lvl_we_i = 1'b1; lvl_idx_i = IDX_W'(idx); lvl_val_i = 3'(val);
    @(negedge clk); lvl_we_i = 1'b0;
  endtask

  task automatic pulse_irq(input logic [NUM_SRC-1:0] m);
    @(negedge clk); irq_i = irq_i | m;
    @(negedge clk); irq_i = irq_i & ~m;
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi_i = 1'b1;
    @(negedge clk); nmi_i = 1'b0;
  endtask

  task automatic mask_en(input int v);
    @(negedge clk); mask_en_i = 1'b1; mask_val_i = 3'(v);
    @(negedge clk); mask_en_i = 1'b0;
  endtask

  task automatic mask_dis();
    @(negedge clk); mask_dis_i = 1'b1;
    @(negedge clk); mask_dis_i = 1'b0;
  endtask

  task automatic ack(input int vec);
    @(negedge clk); ack_i = 1'b1; ack_vec_i = VEC_W'(vec);
    @(negedge clk); ack_i = 1'b0;
  endtask

  task automatic check_req(input string tag, input int v, input int l, input int vec);
    check({tag, " req_valid"}, int'(req_valid_o), v);
    if (v != 0) begin
      check({tag, " req_lvl"}, int'(req_lvl_o), l);
      check({tag, " req_vec"}, int'(req_vec_o), vec);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 acc_o after reset", int'(acc_o), 0);
    check("R1 req_valid after reset", int'(req_valid_o), 0);

    wr_lvl(0, 3); wr_lvl(1, 5); wr_lvl(2, 5); wr_lvl(3, 0); wr_lvl(4, 7);

    // R1: mask resets to 7, so a level-3 request is held back
    pulse_irq(8'h01);
    check_req("R3 single source", 1, 3, 1);
    idle(4);
    check("R1 no accept under reset mask", expq.size(), 0);

    // R5: enable with value 3 admits level 3 (equality)
    expect_acc(3, 1);
    mask_en(3);
    idle(3);
    ack(1);
    check_req("R9 pending cleared by ack", 0, 0, 0);

    // R7: mask 6 blocks level 5; writing 5 accepts at the next edge
    mask_en(6);
    pulse_irq(8'h02);
    check_req("R3 level 5 pending", 1, 5, 2);
    idle(2);
    check("R5 level below mask not accepted", int'(acc_o), 0);
    expect_acc(5, 2);
    mask_en(5);
    check("R7 no strobe in the write cycle", int'(acc_o), 0);
    @(negedge clk);
    check("R7 strobe one edge after mask write", int'(acc_o), 1);

    // R10: while busy nothing more is accepted; R3/R11 highest pending forwarded
    pulse_irq(8'h14);
    idle(3);
    check_req("R11 level 7 saturated to 6", 1, 6, 5);
    expect_acc(6, 5);
    ack(2);
    idle(3);
    expect_acc(5, 3);
    ack(5);
    idle(3);
    ack(3);
    check_req("R9 all cleared", 0, 0, 0);

    // R3 tie: equal levels, lower index first
    expect_acc(5, 2);
    expect_acc(5, 3);
    pulse_irq(8'h06);
    idle(3);
    ack(2);
    idle(3);
    ack(3);

    // R2: level 0 source is ignored
    pulse_irq(8'h08);
    idle(3);
    check_req("R2 level-0 source not forwarded", 0, 0, 0);

    // R8: held-high input sets pending once only
    @(negedge clk); irq_i[0] = 1'b1;
    idle(4);
    check_req("R8 held input pending", 1, 3, 1);
    expect_acc(3, 1);
    mask_en(1);
    idle(3);
    ack(1);
    idle(3);
    check_req("R8 held input not re-set", 0, 0, 0);
    @(negedge clk); irq_i[0] = 1'b0;

    // R6: disable blocks maskable, passes nonmaskable; R4 and R9
    mask_dis();
    pulse_irq(8'h10);
    idle(3);
    check_req("R6 maskable blocked pending", 1, 6, 5);
    check("R6 maskable not accepted", expq.size(), 0);
    expect_acc(7, 0);
    pulse_nmi();
    check_req("R4 nonmaskable forwarded", 1, 7, 0);
    idle(3);
    ack(0);
    check_req("R9 other flag survives ack", 1, 6, 5);
    idle(3);
    check("R6 still blocked after ack", int'(acc_o), 0);
    expect_acc(6, 5);
    mask_en(0);
    idle(3);
    ack(5);
    idle(3);

    check("R10 all expected accepts seen", expq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule